// File: doc/BRIEF.md
# Composite-Field AES Byte Substitution

This block performs the AES byte substitution and its inverse on a full 128-bit state. It has sixteen identical byte lanes, and one mode input selects the direction for all of them. The design has no registers. A round datapath places it between its own state register and the row-shift and column-mix logic. The same hardware serves the encryption path and the decryption path.

No lane reads a 256-entry lookup table. Each lane computes the multiplicative inverse arithmetically:

- It maps the byte into a tower field built as a degree-two extension over GF(2^4).
- It inverts the byte there, using multiplies, squares and a single GF(2^4) inversion.
- It maps the result back.

The isomorphism matrices are derived from the field polynomials at elaboration time.

In the forward direction, the inversion comes first and the affine step follows. In the inverse direction, the inverse affine step comes first and feeds the same inverter. The inverter is therefore shared between the two directions, and only two byte multiplexers differ between them.

Top module: `cf_subbytes`

## Requirements
- R1: With `mode_inv` = 0, each output byte equals the affine transform of the input byte's multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1. The affine output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (indices mod 8), then XOR with bit i of 0x63.
- R2: With `mode_inv` = 1, each output byte is the inverse substitution. Output bit i of the inverse affine step is the XOR of input bits i+2, i+5 and i+7 (mod 8), then XOR with bit i of 0x05. The multiplicative inverse of that result is the output.
- R3: A zero byte inverts to zero. Forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R4: Fixed forward values hold: 0x66 gives 0x33, 0x01 gives 0x7C and 0x53 gives 0xED.
- R5: For every byte x, the inverse substitution applied to the forward substitution of x returns x.
- R6: Byte lane i occupies bits [8i+7:8i] of `state_in` and `state_out`. Each lane is substituted independently, and all lanes use the same `mode_inv`.
- R7: The output settles from the inputs with no clock. A change of input between clock edges shows up before the next edge.
- R8: In neither direction is any output byte equal to its input byte or to the bitwise complement of its input byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_inv | input | 1 | 0 selects the forward substitution, 1 selects the inverse substitution |
| state_in | input | 8*LANES (128) | State bytes to be substituted, lane i in bits [8i+7:8i] |
| state_out | output | 8*LANES (128) | Substituted state bytes, lane aligned with `state_in` |

## Verification
Two functions can meet in one vector:

- A zero byte, which must take the inverter's special path.
- Ordinary non-zero bytes, which take the normal inversion.

The bench provokes this with mixed vectors that place 0x00 and 0x63 beside ordinary values in other lanes. It judges each lane against a reference table built from GF(2^8) arithmetic.

The mode switch can also coincide with a data change. The bench toggles `mode_inv` in consecutive cycles, both over identical data and over changed data. It checks that every lane follows the new direction in the same cycle. Round trips feed captured forward outputs back in inverse mode and expect the original bytes.

// File: rtl/cf_sbox_pkg.sv
package cf_sbox_pkg;

    // Degree-two extension over GF(2^4): y^2 = y + CF_LAMBDA.
    // GF(2^4) itself uses x^4 + x + 1.
    localparam logic [3:0] CF_LAMBDA   = 4'hC;
    localparam logic [3:0] GF16_REDUCE = 4'h3;

    // Affine step rows (row i = base rotated) and constants.
    localparam logic [7:0] AFF_FWD_ROW = 8'h1F;
    localparam logic [7:0] AFF_FWD_C   = 8'h63;
    localparam logic [7:0] AFF_INV_ROW = 8'hA4;
    localparam logic [7:0] AFF_INV_C   = 8'h05;

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        int k;
        k = n % 8;
        return (v << k) | (v >> (8 - k));
    endfunction

    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] t;
        acc = '0;
        t   = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ t;
            t = t[3] ? ({t[2:0], 1'b0} ^ GF16_REDUCE) : {t[2:0], 1'b0};
        end
        return acc;
    endfunction

    // a^14 = a^-1 for non-zero a, and 0 for 0.
    function automatic logic [3:0] gf16_inv(input logic [3:0] a);
        logic [3:0] p2, p4, p8;
        p2 = gf16_mul(a, a);
        p4 = gf16_mul(p2, p2);
        p8 = gf16_mul(p4, p4);
        return gf16_mul(gf16_mul(p2, p4), p8);
    endfunction

    // Multiply in the tower field; the high nibble is the y coefficient.
    function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] hh;
        logic [3:0] hi;
        logic [3:0] lo;
        hh = gf16_mul(a[7:4], b[7:4]);
        hi = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
        lo = gf16_mul(hh, CF_LAMBDA) ^ gf16_mul(a[3:0], b[3:0]);
        return {hi, lo};
    endfunction

    // Column j of m sits in m[8j+7:8j].
    function automatic logic [7:0] mat_apply(input logic [63:0] m, input logic [7:0] v);
        logic [7:0] r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            if (v[j]) r = r ^ m[8*j +: 8];
        end
        return r;
    endfunction

    // Find a root of x^8+x^4+x^3+x+1 inside the tower field.
    function automatic logic [7:0] find_beta();
        logic [7:0] b, b2, b3, b4, b8, p, found;
        logic       hit;
        found = '0;
        hit   = 1'b0;
        for (int c = 2; c < 256; c++) begin
            b  = 8'(c);
            b2 = cf_mul(b, b);
            b3 = cf_mul(b2, b);
            b4 = cf_mul(b2, b2);
            b8 = cf_mul(b4, b4);
            p  = b8 ^ b4 ^ b3 ^ b ^ 8'h01;
            if (!hit && p == 8'h00) begin
                found = b;
                hit   = 1'b1;
            end
        end
        return found;
    endfunction

    function automatic logic [63:0] build_to_mat();
        logic [63:0] m;
        logic [7:0]  beta, p;
        m    = '0;
        beta = find_beta();
        p    = 8'h01;
        for (int j = 0; j < 8; j++) begin
            m[8*j +: 8] = p;
            p = cf_mul(p, beta);
        end
        return m;
    endfunction

    function automatic logic [63:0] build_from_mat(input logic [63:0] to_m);
        logic [63:0] m;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            for (int c = 0; c < 256; c++) begin
                if (mat_apply(to_m, 8'(c)) == (8'h01 << j)) m[8*j +: 8] = 8'(c);
            end
        end
        return m;
    endfunction

    // Rotation form of both affine steps, used by checks.
    function automatic logic [7:0] aff_ref(input logic inverse, input logic [7:0] v);
        if (inverse)
            return rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ AFF_INV_C;
        else
            return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFF_FWD_C;
    endfunction

    localparam logic [63:0] TO_CF   = build_to_mat();
    localparam logic [63:0] FROM_CF = build_from_mat(TO_CF);

endpackage

// File: rtl/cf_affine.sv
module cf_affine
    import cf_sbox_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [7:0] a_in,
    output logic [7:0] a_out
);

    localparam logic [7:0] BASE_ROW = INVERSE ? AFF_INV_ROW : AFF_FWD_ROW;
    localparam int         ROT_OFS  = INVERSE ? 0 : 4;
    localparam logic [7:0] ADD_C    = INVERSE ? AFF_INV_C : AFF_FWD_C;

    for (genvar i = 0; i < 8; i++) begin : g_row
        localparam logic [7:0] ROW = rotl8(BASE_ROW, i + ROT_OFS);
        assign a_out[i] = (^(a_in & ROW)) ^ ADD_C[i];
    end

    // The opposite step must undo this one.
    always_comb begin
        if (!$isunknown(a_in)) begin
            assert_affine_pair_R5: assert (aff_ref(!INVERSE, a_out) == a_in);
        end
    end

endmodule

// File: rtl/cf_field_inv.sv
module cf_field_inv
    import cf_sbox_pkg::*;
(
    input  logic [7:0] x,
    output logic [7:0] y
);

    typedef struct packed {
        logic [7:0] cf;
        logic [3:0] hi;
        logic [3:0] lo;
        logic [3:0] nrm;
        logic [3:0] nrm_inv;
        logic [7:0] cf_inv;
    } inv_work_t;

    inv_work_t w_d;

    always_comb begin
        w_d.cf      = mat_apply(TO_CF, x);
        w_d.hi      = w_d.cf[7:4];
        w_d.lo      = w_d.cf[3:0];
        w_d.nrm     = gf16_mul(gf16_mul(w_d.hi, w_d.hi), CF_LAMBDA)
                    ^ gf16_mul(w_d.hi, w_d.lo)
                    ^ gf16_mul(w_d.lo, w_d.lo);
        w_d.nrm_inv = gf16_inv(w_d.nrm);
        w_d.cf_inv  = {gf16_mul(w_d.hi, w_d.nrm_inv),
                       gf16_mul(w_d.hi ^ w_d.lo, w_d.nrm_inv)};
        y           = mat_apply(FROM_CF, w_d.cf_inv);
    end

    always_comb begin
        if (!$isunknown(x)) begin
            assert_iso_roundtrip_R1: assert (mat_apply(FROM_CF, w_d.cf) == x);
            assert_zero_maps_zero_R3: assert (x != 8'h00 || y == 8'h00);
            if (x != 8'h00) begin
                assert_inverse_product_R1: assert (cf_mul(w_d.cf, w_d.cf_inv) == 8'h01);
            end
        end
    end

endmodule

// File: rtl/cf_sbox_byte.sv
module cf_sbox_byte (
    input  logic       mode_inv,
    input  logic [7:0] b_in,
    output logic [7:0] b_out
);

    logic [7:0] pre_aff;
    logic [7:0] inv_in;
    logic [7:0] inv_out;
    logic [7:0] post_aff;

    cf_affine #(.INVERSE(1'b1)) u_pre (
        .a_in  (b_in),
        .a_out (pre_aff)
    );

    assign inv_in = mode_inv ? pre_aff : b_in;

    cf_field_inv u_inv (
        .x (inv_in),
        .y (inv_out)
    );

    cf_affine #(.INVERSE(1'b0)) u_post (
        .a_in  (inv_out),
        .a_out (post_aff)
    );

    assign b_out = mode_inv ? inv_out : post_aff;

    always_comb begin
        if (!$isunknown({mode_inv, b_in})) begin
            assert_no_fixed_point_R8: assert (b_out != b_in && b_out != ~b_in);
        end
    end

endmodule

// File: rtl/cf_subbytes.sv
module cf_subbytes #(
    parameter int LANES = 16
) (
    input  logic                 mode_inv,
    input  logic [LANES*8-1:0]   state_in,
    output logic [LANES*8-1:0]   state_out
);

    localparam int BYTE_W = 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cf_sbox_byte u_byte (
            .mode_inv (mode_inv),
            .b_in     (state_in[BYTE_W*i +: BYTE_W]),
            .b_out    (state_out[BYTE_W*i +: BYTE_W])
        );
    end

endmodule

// File: tb/sim_cf_subbytes.sv
`timescale 1ns/1ps
module sim_cf_subbytes;

    localparam int LANES = 16;
    localparam int W     = LANES * 8;

    logic         clk = 1'b0;
    logic         mode_inv;
    logic [W-1:0] st_in;
    logic [W-1:0] st_out;
    int           total = 0;
    int           bad   = 0;
    bit           done  = 1'b0;

    always #2.5 clk = ~clk;

    cf_subbytes #(.LANES(LANES)) u0 (
        .mode_inv  (mode_inv),
        .state_in  (st_in),
        .state_out (st_out)
    );

    logic [7:0] ref_fwd [256];
    logic [7:0] ref_inv [256];

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, t;
        r = '0;
        t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ t;
            t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_recip(input logic [7:0] a);
        logic [7:0] r;
        r = '0;
        for (int c = 1; c < 256; c++) begin
            if (ref_mul(a, 8'(c)) == 8'h01) r = 8'(c);
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_aff(input logic [7:0] a);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_state(input logic m, input logic [W-1:0] d);
        logic [W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[8*i +: 8] = m ? ref_inv[d[8*i +: 8]] : ref_fwd[d[8*i +: 8]];
        end
        return r;
    endfunction

    typedef struct {
        logic         m;
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t sbq[$];

    task automatic drive(input logic m, input logic [W-1:0] d, input logic [W-1:0] e, input string tag);
        sb_item_t it;
        @(posedge clk);
        #1;
        mode_inv = m;
        st_in    = d;
        it.m     = m;
        it.exp   = e;
        it.tag   = tag;
        sbq.push_back(it);
    endtask

    task automatic check_now(input logic [W-1:0] got, input logic [W-1:0] e, input string tag);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
    endtask

    // Monitor: compare at the falling edge after each drive.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            total++;
            if (st_out !== it.exp) begin
                bad++;
                $display("FAIL %s (mode %0d): got %h expected %h", it.tag, it.m, st_out, it.exp);
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d, cap, fp_bad;
        mode_inv = 1'b0;
        st_in    = '0;

        for (int x = 0; x < 256; x++) begin
            ref_fwd[x] = ref_aff(ref_recip(8'(x)));
        end
        for (int x = 0; x < 256; x++) begin
            ref_inv[ref_fwd[x]] = 8'(x);
        end

        // R3: all-zero state, forward
        drive(1'b0, '0, {LANES{8'h63}}, "R3 zero forward");
        // R3: inverse of 0x63 everywhere
        drive(1'b1, {LANES{8'h63}}, '0, "R3 inverse of 63");
        // R4 and R6: fixed values in chosen lanes, others zero
        drive(1'b0, {{(LANES-1){8'h00}}, 8'h66}, {{(LANES-1){8'h63}}, 8'h33}, "R4 66->33 lane0");
        drive(1'b0, {8'h53, {(LANES-2){8'h00}}, 8'h01},
              {8'hED, {(LANES-2){8'h63}}, 8'h7C}, "R4 53->ED,01->7C R6 lane order");
        drive(1'b1, {8'hED, {(LANES-2){8'h00}}, 8'h7C},
              {8'h53, {(LANES-2){ref_inv[8'h00]}}, 8'h01}, "R2 fixed inverse values R6");

        // R1: forward sweep over all bytes
        for (int k = 0; k < 256 / LANES; k++) begin
            for (int i = 0; i < LANES; i++) d[8*i +: 8] = 8'(k*LANES + i);
            drive(1'b0, d, exp_state(1'b0, d), "R1 forward sweep");
        end
        // R2: inverse sweep over all bytes
        for (int k = 0; k < 256 / LANES; k++) begin
            for (int i = 0; i < LANES; i++) d[8*i +: 8] = 8'(255 - (k*LANES + i));
            drive(1'b1, d, exp_state(1'b1, d), "R2 inverse sweep");
        end

        // R5 round trip through captured outputs, with R8 lane checks
        for (int k = 0; k < 256 / LANES; k++) begin
            for (int i = 0; i < LANES; i++) d[8*i +: 8] = 8'(k*LANES + i) ^ 8'h5A;
            drive(1'b0, d, exp_state(1'b0, d), "R5 forward leg");
            @(negedge clk);
            #0.5;
            cap    = st_out;
            fp_bad = '0;
            for (int i = 0; i < LANES; i++) begin
                if (cap[8*i +: 8] == d[8*i +: 8] || cap[8*i +: 8] == ~d[8*i +: 8])
                    fp_bad[8*i +: 8] = 8'hFF;
            end
            check_now(fp_bad, '0, "R8 no fixed point");
            drive(1'b1, cap, d, "R5 inverse returns original");
        end

        // R6: mode toggles each cycle over identical data, then with data change
        d = {8'h00, 8'h63, 8'h66, 8'h33, 8'hFF, 8'h01, 8'h7C, 8'h80,
             8'h00, 8'hED, 8'h53, 8'h10, 8'hAA, 8'h55, 8'h00, 8'hC3};
        drive(1'b0, d, exp_state(1'b0, d), "R6 mixed forward");
        drive(1'b1, d, exp_state(1'b1, d), "R6 mixed inverse same data");
        drive(1'b0, d, exp_state(1'b0, d), "R6 mixed forward again");
        drive(1'b1, ~d, exp_state(1'b1, ~d), "R6 mode and data change");

        // R7: change input between edges, see output before next edge
        @(negedge clk);
        #0.5;
        st_in = {LANES{8'h66}};
        #0.5;
        check_now(st_out, {LANES{8'h7C ^ 8'h7C ^ ref_inv[8'h66]}}, "R7 mid-cycle inverse");
        mode_inv = 1'b0;
        #0.5;
        check_now(st_out, {LANES{8'h33}}, "R7 mid-cycle forward");

        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule